// File: doc/BRIEF.md
# Level-Sensed DMA Request Activation Controller

This block handles requests for one DMA channel that runs in single-address mode. An external requester drives an active-low request line. The block brings that line into the clock domain through a synchronizer. Once software enables the channel, the block samples the synchronized level on every clock. A low sample latches a pending request. The pending request is cleared when the channel is activated. The block then asks for the bus, and after it sees a grant it runs one single-address bus cycle. During that cycle an acknowledge strobe tells the requester that its data is being read or written. The same cycle serves as both the source access and the destination access.

A down-counter holds the number of transfers still to do. Software loads it before enabling the channel. The counter decrements at the end of every bus cycle. When the last transfer completes, the enable drops and a one-cycle done pulse is raised. New requests are ignored from activation until the bus cycle ends. An optional slow re-arm setting adds one more dead cycle before the next request can be accepted.

A count of zero behaves as a full wrap of the counter, so the channel runs until the count comes back around to one. The register decode sits outside the block. It presents the enable write as a strobe plus a data bit.

Top module: `dma_lvl_act`

## Requirements
- R1: `en_wr` high with `en_wdata` = 1 sets the channel enable at that clock edge. Sampling of the synchronized request starts at the next edge. With the request already low and synchronized, `bus_req` rises at the second edge after the enable-write edge.
- R2: `req_n` passes through a two-flop synchronizer. A fall of `req_n` just before edge A raises `bus_req` after edge A+3. While `req_n` stays high, no bus cycle starts.
- R3: A pending request is cleared when the channel is activated. A single latched request gives exactly one bus cycle.
- R4: `bus_req` rises when the channel is activated. It stays high while waiting for `bus_gnt` and through the whole bus cycle, then falls together with `ack`. `ack` rises only at the edge after `bus_gnt` was high. It stays high for exactly `XFER_CYC` cycles (default 3) and is never high without `bus_req`.
- R5: New requests are ignored from activation until the bus cycle ends. With `slow_rearm` = 0 and the request held low, `bus_req` rises again 2 cycles after `ack` falls. With `slow_rearm` = 1 it rises 3 cycles after `ack` falls.
- R6: `cnt_load` loads `cnt_value` into the transfer counter. With the request held low, the channel performs exactly `cnt_value` bus cycles and then stops.
- R7: `done` is high for exactly one cycle, in the same cycle in which `ack` of the last transfer falls. The enable clears at that point, and no further `bus_req` follows.
- R8: Clearing the enable (`en_wr` high with `en_wdata` = 0) while a request is pending but not yet activated discards the request. No bus cycle starts.
- R9: During and right after reset, `bus_req`, `ack` and `done` are low, and the enable, the pending request and the counter are cleared.
- R10: From latching a request to the bus being released, at least 3 cycles pass. Elaboration rejects `XFER_CYC` < 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_wr | input | 1 | Write strobe for the channel enable |
| en_wdata | input | 1 | Enable value written when `en_wr` is high |
| slow_rearm | input | 1 | Adds one dead cycle after each bus cycle |
| cnt_load | input | 1 | Loads the transfer counter |
| cnt_value | input | CNT_W | Transfer count to load |
| req_n | input | 1 | Asynchronous active-low transfer request |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_req | output | 1 | Bus request, held until the bus cycle ends |
| ack | output | 1 | Single-address transfer acknowledge |
| done | output | 1 | One-cycle pulse when the count is exhausted |

## Verification
The bench checks the exact edge on which sampling starts after an enable write, and the exact delay through the synchronizer. A design that samples one edge early or late, or that drops a flop from the synchronizer, shifts the first `bus_req` and fails that check.

It holds the request low across back-to-back transfers and measures the re-arm gap for both values of the slow re-arm bit. A design that clears the pending request at the end of the transfer, or that ignores the extra dead cycle, shows the wrong gap or an extra bus cycle. A one-cycle request pulse shows whether a pending request is cleared at activation.

Further tests clear the enable between latching and activation, and check the done pulse and the total transfer count. A design that still starts the discarded transfer, or whose counter is off by one, is caught by these tests.

// File: rtl/dla_pkg.sv
package dla_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_BREQ = 2'd1,
      ST_XFER = 2'd2,
      ST_GAP  = 2'd3
   } dla_state_e;
endpackage

// File: rtl/dla_sync.sv
module dla_sync #(
   parameter int  STAGES    = 2,
   parameter bit  RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q
);
   logic [STAGES-1:0] sh;

   if (STAGES < 2) begin : g_bad_stages
      $error("dla_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= {STAGES{RESET_VAL}};
      else        sh <= {sh[STAGES-2:0], d_async};
   end

   assign q = sh[STAGES-1];
endmodule

// File: rtl/dla_tcount.sv
module dla_tcount #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             last
);
   logic [CNT_W-1:0] cnt_q;

   if (CNT_W < 2) begin : g_bad_width
      $error("dla_tcount: CNT_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (load) cnt_q <= load_val;
      else if (dec)  cnt_q <= cnt_q - 1'b1;
   end

   assign last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/dla_seq.sv
module dla_seq
   import dla_pkg::*;
#(
   parameter int XFER_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   input  logic slow_rearm,
   input  logic bus_gnt,
   output logic accept,
   output logic bus_req,
   output logic ack,
   output logic xfer_end
);
   dla_state_e state_q, state_d;
   logic       last_beat;

   if (XFER_CYC == 1) begin : g_one_beat
      assign last_beat = 1'b1;
   end else begin : g_multi_beat
      localparam int BW = $clog2(XFER_CYC);
      logic [BW-1:0] beat_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 beat_q <= '0;
         else if (state_q != ST_XFER) beat_q <= '0;
         else if (!last_beat)        beat_q <= beat_q + 1'b1;
      end
      assign last_beat = (beat_q == BW'(XFER_CYC - 1));
   end

   always_comb begin
      state_d  = state_q;
      xfer_end = 1'b0;
      unique case (state_q)
         ST_IDLE: if (go) state_d = ST_BREQ;
         ST_BREQ: if (bus_gnt) state_d = ST_XFER;
         ST_XFER: if (last_beat) begin
            xfer_end = 1'b1;
            state_d  = slow_rearm ? ST_GAP : ST_IDLE;
         end
         ST_GAP:  state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign accept  = (state_q == ST_IDLE);
   assign bus_req = (state_q == ST_BREQ) || (state_q == ST_XFER);
   assign ack     = (state_q == ST_XFER);
endmodule

// File: rtl/dma_lvl_act.sv
module dma_lvl_act #(
   parameter int CNT_W       = 16,
   parameter int XFER_CYC    = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_wr,
   input  logic             en_wdata,
   input  logic             slow_rearm,
   input  logic             cnt_load,
   input  logic [CNT_W-1:0] cnt_value,
   input  logic             req_n,
   input  logic             bus_gnt,
   output logic             bus_req,
   output logic             ack,
   output logic             done
);
   // R10: the bus cycle must last at least one clock
   if (XFER_CYC < 1) begin : g_bad_xfer
      $error("dma_lvl_act: XFER_CYC must be at least 1");
   end

   logic req_s, req_on;
   logic en_q, en_nxt, pend_q, pend_nxt, done_q;
   logic accept, activate, xfer_end, cnt_last, term;

   dla_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_async(req_n), .q(req_s)
   );
   assign req_on = ~req_s;

   dla_tcount #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_value),
      .dec(xfer_end), .last(cnt_last)
   );

   dla_seq #(.XFER_CYC(XFER_CYC)) u_seq (
      .clk(clk), .rst_n(rst_n), .go(activate), .slow_rearm(slow_rearm),
      .bus_gnt(bus_gnt), .accept(accept), .bus_req(bus_req), .ack(ack),
      .xfer_end(xfer_end)
   );

   assign term = xfer_end & cnt_last;

   always_comb begin
      if (en_wr && en_wdata)               en_nxt = 1'b1;
      else if ((en_wr && !en_wdata) || term) en_nxt = 1'b0;
      else                                 en_nxt = en_q;
   end

   // activation needs the enable to stay set through this edge
   assign activate = en_q & en_nxt & pend_q & accept;

   always_comb begin
      if (!en_nxt)                       pend_nxt = 1'b0;
      else if (activate)                 pend_nxt = 1'b0;
      else if (en_q && accept && req_on) pend_nxt = 1'b1;
      else                               pend_nxt = pend_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         pend_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         en_q   <= en_nxt;
         pend_q <= pend_nxt;
         done_q <= term;
      end
   end

   assign done = done_q;
endmodule

// File: rtl/dma_lvl_act_chk.sv
module dma_lvl_act_chk #(
   parameter int XFER_CYC = 3
) (
   input logic clk,
   input logic rst_n,
   input logic bus_req,
   input logic bus_gnt,
   input logic ack,
   input logic done
);
   int unsigned run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   run_q <= 0;
      else if (ack) run_q <= run_q + 1;
      else          run_q <= 0;
   end

   a_r4_ack_needs_busreq: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> bus_req);

   a_r4_ack_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack) |-> $past(bus_gnt));

   a_r4_release_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ack) |-> !bus_req);

   a_r4_ack_length: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= XFER_CYC);

   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r7_done_at_last_ack: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $fell(ack));
endmodule

bind dma_lvl_act dma_lvl_act_chk #(.XFER_CYC(XFER_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
   .ack(ack), .done(done)
);

// File: tb/dma_lvl_act_tb_top.sv
module dma_lvl_act_tb_top;
   localparam int CNT_W = 16;
   localparam int XFER  = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic en_wr = 1'b0, en_wdata = 1'b0, slow_rearm = 1'b0, cnt_load = 1'b0;
   logic [CNT_W-1:0] cnt_value = '0;
   logic req_n = 1'b1, bus_gnt = 1'b0;
   logic bus_req, ack, done;

   int checks = 0, errors = 0, cyc = 0, glat = 0, wcnt = 0;
   bit finished = 0;

   dma_lvl_act #(.CNT_W(CNT_W), .XFER_CYC(XFER)) dut_i (
      .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
      .slow_rearm(slow_rearm), .cnt_load(cnt_load), .cnt_value(cnt_value),
      .req_n(req_n), .bus_gnt(bus_gnt), .bus_req(bus_req), .ack(ack),
      .done(done)
   );

   always #5 clk = ~clk;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !finished) begin
         errors++;
         $display("FAIL watchdog: actual cycles %0d expected < 100000", cyc);
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   // bus arbiter model: grants glat cycles after seeing bus_req
   always @(negedge clk) begin
      if (bus_req && !ack) begin
         if (wcnt >= glat) bus_gnt <= 1'b1;
         else              wcnt <= wcnt + 1;
      end else begin
         bus_gnt <= 1'b0;
         wcnt    <= 0;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   function automatic int exp_gap(input bit dly);
      return 2 + int'(dly);
   endfunction

   function automatic int exp_breq_len(input int gl);
      return gl + 1 + XFER;
   endfunction

   task automatic load_count(input int n);
      cnt_load = 1'b1; cnt_value = CNT_W'(n); step(); cnt_load = 1'b0;
   endtask

   // request held low; enable written; observe n transfers
   task automatic run_trial(input int n, input bit dly, input int gl);
      bit pb = 0, pa = 0, first = 1, seen_done = 0;
      int brise = 0, arise = 0, afall = 0, acks = 0, dcnt = 0, after = 0, late_br = 0;
      glat = gl; slow_rearm = dly; req_n = 1'b0;
      step(); step(); step();
      load_count(n);
      en_wr = 1'b1; en_wdata = 1'b1;
      for (int k = 1; k < 400; k++) begin
         step();
         en_wr = 1'b0;
         if (bus_req && !pb) begin
            if (first) chk(k == 3, "R1 first bus_req sample", k, 3);
            else       chk(k - afall == exp_gap(dly), "R5 rearm gap", k - afall, exp_gap(dly));
            first = 0; brise = k;
            if (seen_done) late_br++;
         end
         if (!bus_req && pb)
            chk(k - brise == exp_breq_len(gl), "R4 bus_req length", k - brise, exp_breq_len(gl));
         if (ack && !pa) arise = k;
         if (!ack && pa) begin
            chk(k - arise == XFER, "R4 ack length", k - arise, XFER);
            acks++; afall = k;
         end
         if (done) begin
            dcnt++;
            chk(!ack && pa, "R7 done with last ack fall", int'(ack), 0);
            seen_done = 1;
         end
         pb = bus_req; pa = ack;
         if (seen_done) begin
            after++;
            if (after > 12) break;
         end
      end
      chk(acks == n, "R6 transfer count", acks, n);
      chk(dcnt == 1, "R7 done pulses", dcnt, 1);
      chk(late_br == 0, "R7 no bus_req after done", late_br, 0);
   endtask

   initial begin
      int sv;
      sv = $urandom(32'h5eed_1234);
      step();
      chk(!bus_req && !ack && !done, "R9 outputs in reset", int'(bus_req|ack|done), 0);
      step(); rst_n = 1'b1; step(); step();
      chk(!bus_req && !ack && !done, "R9 outputs after reset", int'(bus_req|ack|done), 0);

      // R2: high request ignored, then synchronizer latency
      begin
         int seen = 0, lat = 0;
         glat = 0; load_count(1);
         en_wr = 1'b1; en_wdata = 1'b1; step(); en_wr = 1'b0;
         for (int k = 0; k < 6; k++) begin step(); if (bus_req) seen++; end
         chk(seen == 0, "R2 high request starts nothing", seen, 0);
         req_n = 1'b0;
         for (int k = 1; k < 20; k++) begin
            step();
            if (bus_req) begin lat = k; break; end
         end
         chk(lat == 4, "R2 sync latency", lat, 4);
         for (int k = 0; k < 20; k++) step();
         req_n = 1'b1; step(); step(); step();
      end

      // R3: single short request gives exactly one cycle
      begin
         int acks = 0, dn = 0;
         bit pa = 0;
         load_count(3);
         en_wr = 1'b1; en_wdata = 1'b1; step(); en_wr = 1'b0;
         step(); req_n = 1'b0; step(); req_n = 1'b1;
         for (int k = 0; k < 30; k++) begin
            step();
            if (!ack && pa) acks++;
            if (done) dn++;
            pa = ack;
         end
         chk(acks == 1, "R3 one cycle per latched request", acks, 1);
         chk(dn == 0, "R3 no done with count left", dn, 0);
         en_wr = 1'b1; en_wdata = 1'b0; step(); en_wr = 1'b0; step();
      end

      // R8: clear enable between latch and activation
      begin
         int seen = 0;
         req_n = 1'b0; step(); step(); step();
         load_count(2);
         en_wr = 1'b1; en_wdata = 1'b1; step();
         en_wr = 1'b0; step();
         en_wr = 1'b1; en_wdata = 1'b0; step();
         en_wr = 1'b0;
         for (int k = 0; k < 15; k++) begin step(); if (bus_req) seen++; end
         chk(seen == 0, "R8 discarded request", seen, 0);
      end

      // directed corners, then constrained random trials (R5 R6 R7 R4)
      run_trial(1, 1'b0, 0);
      run_trial(2, 1'b1, 0);
      run_trial(3, 1'b0, 3);
      for (int t = 0; t < 16; t++)
         run_trial(1 + int'($urandom_range(4)), 1'($urandom_range(1)), int'($urandom_range(3)));

      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule